// File: doc/BRIEF.md
# Not-Most-Recently-Used Victim Pointer

This block chooses the eviction candidate for a fully associative structure of 64 entries. It holds one pointer register, and that register names the entry to replace next. The tag match and data arrays sit elsewhere. They report each access to this block as a strobe and the 6-bit index of the entry that was touched. They also raise an allocate strobe when a fill consumes the current victim.

The pointer moves forward by one entry only when the entry it names is used. A use is an access that hits the named entry or an allocate that fills it. Accesses to any other entry leave the pointer where it is. As a result the entry used most recently is never the next victim. The policy is cheaper than true LRU and makes no claim beyond this.

Top module: `nmru_victim_ptr`

## Requirements
- R1: After reset the victim index is 0.
- R2: An access strobe whose index equals the current victim index moves the victim to the next index one clock later.
- R3: An access strobe whose index differs from the victim index, with no allocate, leaves the victim index unchanged.
- R4: An allocate strobe, which always fills the entry the victim index names, moves the victim to the next index one clock later.
- R5: When an access and an allocate occur in the same cycle, the victim advances by exactly one, whatever index the access carries.
- R6: The index advances modulo 64, so the entry after 63 is 0.
- R7: A cycle with both strobes low leaves the victim index unchanged, whatever value the access index input holds.
- R8: The victim index never changes by any amount other than zero or one step. Right after a use of the named entry, the victim differs from that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An entry was accessed this cycle |
| acc_idx | input | 6 | Index of the accessed entry |
| alloc_valid | input | 1 | The current victim is being filled this cycle |
| victim_idx | output | 6 | Index of the current replacement candidate |

## Verification
The bench goes after three corner cases.

- A same-cycle access and allocate. A design that adds the two causes would step the pointer by two.
- An access to an entry other than the pointed one, including a stale pointer value. A design that advances on any hit would evict recently used entries.
- The step from entry 63. A design with a wrong wrap would land outside the structure or stick at 63.

The bench also drives a pointed-entry index while the access strobe is low. A design that ignored the strobe would advance there. A mid-run reset must return the pointer to 0.

// File: rtl/nmru_pkg.sv
package nmru_pkg;
    localparam int unsigned ENTRIES = 64;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        idx_t ptr;
    } ptr_state_t;
endpackage

// File: rtl/nmru_hit_detect.sv
module nmru_hit_detect
    import nmru_pkg::*;
(
    input  logic acc_valid,
    input  idx_t acc_idx,
    input  logic alloc_valid,
    input  idx_t cur_ptr,
    output logic use_hit
);
    logic acc_match;

    always_comb begin
        acc_match = acc_valid && (acc_idx == cur_ptr);
        use_hit   = acc_match || alloc_valid;
    end
endmodule

// File: rtl/nmru_wrap_inc.sv
module nmru_wrap_inc #(
    parameter int unsigned N = 64,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    generate
        if ((1 << W) == N) begin : g_pow2
            always_comb nxt = cur + W'(1);
        end else begin : g_cmp
            always_comb nxt = (cur == LAST) ? '0 : cur + W'(1);
        end
    endgenerate
endmodule

// File: rtl/nmru_victim_ptr.sv
module nmru_victim_ptr
    import nmru_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [5:0] acc_idx,
    input  logic       alloc_valid,
    output logic [5:0] victim_idx
);
    ptr_state_t st_d, st_q;
    logic       use_hit;
    idx_t       ptr_inc;

    nmru_hit_detect u_hit (
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .alloc_valid(alloc_valid),
        .cur_ptr    (st_q.ptr),
        .use_hit    (use_hit)
    );

    nmru_wrap_inc #(.N(ENTRIES), .W(IDX_W)) u_inc (
        .cur(st_q.ptr),
        .nxt(ptr_inc)
    );

    always_comb begin
        st_d = st_q;
        if (use_hit) begin
            st_d.ptr = ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_idx = st_q.ptr;
endmodule

// File: rtl/nmru_victim_ptr_chk.sv
module nmru_victim_ptr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [5:0] acc_idx,
    input logic       alloc_valid,
    input logic [5:0] victim_idx
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> victim_idx == 6'd0); // R1

    AST_SELF_HIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_idx == victim_idx) |=> victim_idx != $past(acc_idx)); // R2

    AST_OTHER_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_idx != victim_idx && !alloc_valid) |=> $stable(victim_idx)); // R3

    AST_ALLOC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> victim_idx == $past(victim_idx) + 6'd1); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !alloc_valid) |=> $stable(victim_idx)); // R7

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid || alloc_valid) |=>
            (victim_idx == $past(victim_idx) || victim_idx == $past(victim_idx) + 6'd1)); // R8
endmodule

bind nmru_victim_ptr nmru_victim_ptr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .alloc_valid(alloc_valid),
    .victim_idx (victim_idx)
);

// File: tb/nmru_victim_ptr_tb.sv
module nmru_victim_ptr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_idx = '0;
    logic       alloc_valid = 1'b0;
    logic [5:0] victim_idx;

    int checks = 0;
    int errors = 0;

    // {acc_valid, acc_idx, alloc_valid, expected victim after the edge}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 6'd0, 1'b0, 6'd0},  // R7 idle
        {1'b1, 6'd5, 1'b0, 6'd0},  // R3 other entry
        {1'b1, 6'd0, 1'b0, 6'd1},  // R2 pointed entry
        {1'b1, 6'd1, 1'b0, 6'd2},  // R2
        {1'b0, 6'd9, 1'b1, 6'd3},  // R4 allocate
        {1'b1, 6'd3, 1'b1, 6'd4},  // R5 both on pointed entry
        {1'b1, 6'd7, 1'b1, 6'd5},  // R5 both, access elsewhere
        {1'b1, 6'd4, 1'b0, 6'd5},  // R3 stale pointer value
        {1'b1, 6'd5, 1'b0, 6'd6},  // R2
        {1'b0, 6'd6, 1'b0, 6'd6},  // R7 index matches, strobe low
        {1'b0, 6'd0, 1'b0, 6'd6}   // R7
    };

    nmru_victim_ptr u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .alloc_valid(alloc_valid),
        .victim_idx (victim_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [5:0] exp);
        checks++;
        if (victim_idx !== exp) begin
            errors++;
            $display("FAIL %s victim=%0d expected=%0d", req, victim_idx, exp);
        end
    endtask

    task automatic step(input logic av, input logic [5:0] ai, input logic al);
        @(negedge clk);
        acc_valid   = av;
        acc_idx     = ai;
        alloc_valid = al;
        @(posedge clk);
        #1;
        acc_valid   = 1'b0;
        alloc_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 6'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][13], VEC[i][12:7], VEC[i][6]);
            check($sformatf("vec%0d R2-R7 table", i), VEC[i][5:0]);
        end

        // Walk forward by allocates to entry 63, then wrap (R6)
        for (int i = 0; i < 57; i++) begin
            step(1'b0, 6'd0, 1'b1);
        end
        check("R4", 6'd63);
        step(1'b1, 6'd63, 1'b0);
        check("R6", 6'd0);
        step(1'b0, 6'd0, 1'b0);
        check("R7", 6'd0);

        // Wrap through allocate while an access also hits 63 (R5, R6)
        for (int i = 0; i < 63; i++) begin
            step(1'b0, 6'd0, 1'b1);
        end
        check("R4", 6'd63);
        step(1'b1, 6'd63, 1'b1);
        check("R5 R6", 6'd0);

        // After a use of the pointed entry, it is no longer the victim (R8)
        step(1'b1, 6'd0, 1'b0);
        check("R8", 6'd1);

        // Mid-run reset (R1)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 6'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 6'd1, 1'b0);
        check("R3", 6'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule